// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block turns the attributes of each external bus cycle into active-low select lines for memories and peripherals. It has a bank of channels. Each channel stores a base address with a block-size code, an option word and a two-bit pin-function code. A channel's select line goes low only when every attribute of the cycle falls inside what the channel accepts: the address, the address-space type, the direction, the byte lanes and, on interrupt-acknowledge cycles, the interrupt level. The select is also gated by the strobe the channel is tied to. When an internal module claims the address, every select and acknowledge is held off.

Channel 0 is the boot channel. Out of reset it decodes the whole lowest megabyte when the boot strap reports an 8-bit or 16-bit expanded bus. Every other channel stays silent until software writes non-zero direction and lane fields. A channel can also end the cycle itself. It raises a data-size acknowledge, or an autovector acknowledge on interrupt-acknowledge cycles, a programmed number of clocks after the address strobe rises.

The block decodes cycles and does not carry a data stream, so there is no valid/ready handshake. The configuration write port and all bus inputs are plain, single-cycle qualified pins with no back-pressure. A configuration write takes effect on the clock edge where `cfg_we` is high.

Top module: `chip_select_decoder`

## Requirements
- R1: A channel's address matches when the address bits at and above log2(block size) equal the stored base. The base register holds address bits [23:11] in bits [15:3] and the size code in bits [2:0]. Codes 0..7 select 2K, 8K, 16K, 64K, 128K, 256K, 512K and 1M bytes.
- R2: The direction field (option bits [1:0]) decodes as 00 off, 01 reads only, 10 writes only, 11 both. A read has `bus_write`=0.
- R3: The lane field (option bits [3:2]) decodes as 00 off, 01 lower byte, 10 upper byte, 11 both. A cycle matches when at least one of its `bus_lanes` bits (bit0 lower, bit1 upper) is enabled.
- R4: The space field (option bits [5:4]) works as follows. Bit 4 admits user cycles (`bus_space`=0) and bit 5 admits supervisor cycles (`bus_space`=1). The value 00 admits only interrupt-acknowledge cycles (`bus_space`=2), and only when the level field (option bits [8:6]) is 0 or equals `bus_ipl`. `bus_space`=3 never matches.
- R5: `cs_n[i]` is low only when every field of channel i matches. Several channels that match the same cycle all assert together.
- R6: While `int_claim` is high, every `cs_n` bit is high and neither acknowledge is raised.
- R7: After reset, channels 1 and up never assert. Any channel whose direction field or lane field is 00 never asserts.
- R8: With `boot_mode` 01 or 10 at reset, channel 0 comes up as a chip select: base 0, size 1M, both directions, both lanes, user or supervisor, wait 3. With 00 or 11 it comes up disabled, with its pin on alternate function A.
- R9: The pin field (`cfg_reg`=2, data bits [1:0]) works as follows. 00 gives the pin to alternate function A (`alt_a` high) and 01 gives it to alternate function B (`alt_b` high). 1x makes the pin a chip select. A pin outside chip-select mode keeps `cs_n` high and raises no acknowledge.
- R10: Option bit 13 picks the gating strobe. When it is 0 the select follows `bus_as`; when it is 1 the select follows `bus_ds`.
- R11: Option bits [12:9] hold a wait count W. A matched cycle raises `size_ack` while `bus_as` is high, starting W rising clock edges after `bus_as` was first seen high. W=15 gives no acknowledge.
- R12: When option bit 14 is set and the cycle is an interrupt acknowledge, the same timing raises `vec_ack` instead of `size_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 2 | Bus-width strap: 01 8-bit, 10 16-bit expanded, else single-chip |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel index for the write |
| cfg_reg | input | 2 | 0 base, 1 option, 2 pin function, 3 ignored |
| cfg_wdata | input | 16 | Write data |
| bus_addr | input | 24 | Cycle address |
| bus_space | input | 2 | 0 user, 1 supervisor, 2 interrupt acknowledge, 3 reserved |
| bus_write | input | 1 | 1 for a write cycle |
| bus_lanes | input | 2 | Active byte lanes: bit0 lower, bit1 upper |
| bus_ipl | input | 3 | Level being acknowledged |
| bus_as | input | 1 | Address strobe, active high |
| bus_ds | input | 1 | Data strobe, active high |
| int_claim | input | 1 | An internal module owns this address |
| cs_n | output | 4 | Active-low selects, one per channel |
| alt_a | output | 4 | Pin assigned to alternate function A |
| alt_b | output | 4 | Pin assigned to alternate function B |
| size_ack | output | 1 | Internally generated data-size acknowledge |
| vec_ack | output | 1 | Internally generated autovector acknowledge |

## Verification
The assertions assume that the bus inputs and `int_claim` change only between clock edges and describe one cycle at a time. They also assume that `bus_space` is the only indicator of an interrupt-acknowledge cycle. The stimulus drives every input on the falling edge and holds it for a full period. It sweeps address, space, direction, lanes, level, strobes and claim exhaustively over a fixed four-channel setup. Configuration writes happen only while both strobes are low.

// File: rtl/csd_pkg.sv
package csd_pkg;

  typedef enum logic [1:0] {
    SP_USER  = 2'd0,
    SP_SUPER = 2'd1,
    SP_IACK  = 2'd2,
    SP_RSVD  = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    CREG_BASE = 2'd0,
    CREG_OPT  = 2'd1,
    CREG_PIN  = 2'd2,
    CREG_NONE = 2'd3
  } creg_e;

  // 15-bit option word, msb first
  typedef struct packed {
    logic       avec;
    logic       use_ds;
    logic [3:0] wait_n;
    logic [2:0] ipl;
    logic [1:0] space;
    logic [1:0] lanes;
    logic [1:0] rw;
  } opt_t;

  localparam int unsigned OPT_W   = $bits(opt_t);
  localparam logic [3:0]  NO_ACK  = 4'hF;
  localparam int unsigned MIN_BLK = 11;

  // log2 of the block size for a 3-bit size code
  function automatic int unsigned blk_log2(input logic [2:0] code);
    case (code)
      3'd0:    return 11;
      3'd1:    return 13;
      3'd2:    return 14;
      3'd3:    return 16;
      3'd4:    return 17;
      3'd5:    return 18;
      3'd6:    return 19;
      default: return 20;
    endcase
  endfunction

endpackage

// File: rtl/csd_channel.sv
module csd_channel
  import csd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DW     = 16,
  parameter bit BOOT   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_exp,
  input  logic              wr_base,
  input  logic              wr_opt,
  input  logic              wr_pin,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_space,
  input  logic              bus_write,
  input  logic [1:0]        bus_lanes,
  input  logic [2:0]        bus_ipl,
  output logic              matched,
  output logic              use_ds,
  output logic              avec,
  output logic [3:0]        wait_n,
  output logic [1:0]        pin_fn
);

  localparam logic [DW-1:0] BOOT_BASE = {{(DW-3){1'b0}}, 3'd7};
  localparam opt_t BOOT_OPT = '{avec: 1'b0, use_ds: 1'b0, wait_n: 4'd3,
                                ipl: 3'd0, space: 2'b11, lanes: 2'b11, rw: 2'b11};

  logic [DW-1:0]     base_q;
  opt_t              opt_q;
  logic [1:0]        pin_q;
  logic [ADDR_W-1:0] base_addr, mask;
  logic              addr_hit, rw_hit, lane_hit, space_hit, enabled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (BOOT && boot_exp) begin
        base_q <= BOOT_BASE;
        opt_q  <= BOOT_OPT;
        pin_q  <= 2'b11;
      end else begin
        base_q <= '0;
        opt_q  <= '0;
        pin_q  <= BOOT ? 2'b00 : 2'b10;
      end
    end else begin
      if (wr_base) base_q <= wdata;
      if (wr_opt)  opt_q  <= opt_t'(wdata[OPT_W-1:0]);
      if (wr_pin)  pin_q  <= wdata[1:0];
    end
  end

  always_comb begin
    base_addr = {base_q[DW-1:3], {MIN_BLK{1'b0}}};
    mask      = {ADDR_W{1'b1}} << blk_log2(base_q[2:0]);
    addr_hit  = ((bus_addr ^ base_addr) & mask) == '0;
    enabled   = (|opt_q.rw) && (|opt_q.lanes);
    rw_hit    = bus_write ? opt_q.rw[1] : opt_q.rw[0];
    lane_hit  = |(bus_lanes & opt_q.lanes);
    case (space_e'(bus_space))
      SP_USER:  space_hit = opt_q.space[0];
      SP_SUPER: space_hit = opt_q.space[1];
      SP_IACK:  space_hit = (opt_q.space == 2'b00) &&
                            ((opt_q.ipl == 3'd0) || (opt_q.ipl == bus_ipl));
      default:  space_hit = 1'b0;
    endcase
    matched = enabled && pin_q[1] && addr_hit && rw_hit && lane_hit && space_hit;
  end

  assign use_ds = opt_q.use_ds;
  assign avec   = opt_q.avec;
  assign wait_n = opt_q.wait_n;
  assign pin_fn = pin_q;

endmodule

// File: rtl/csd_ack.sv
module csd_ack
  import csd_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_as,
  input  logic                  is_iack,
  input  logic                  claim,
  input  logic [NUM_CS-1:0]     matched,
  input  logic [NUM_CS-1:0]     avec,
  input  logic [NUM_CS-1:0][3:0] wait_n,
  output logic                  size_ack,
  output logic                  vec_ack
);

  logic [3:0] cnt_q;
  logic       s_any, v_any;

  // clocks seen with the address strobe high, saturating
  always_ff @(posedge clk) begin
    if (!rst_n || !bus_as) cnt_q <= '0;
    else if (cnt_q != 4'hF) cnt_q <= cnt_q + 4'd1;
  end

  always_comb begin
    s_any = 1'b0;
    v_any = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (matched[i] && (wait_n[i] != NO_ACK) && (cnt_q >= wait_n[i])) begin
        if (avec[i] && is_iack) v_any = 1'b1;
        else                    s_any = 1'b1;
      end
    end
  end

  assign size_ack = s_any && bus_as && !claim;
  assign vec_ack  = v_any && bus_as && !claim;

endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder
  import csd_pkg::*;
#(
  parameter  int NUM_CS = 4,
  parameter  int ADDR_W = 24,
  localparam int DW     = ADDR_W - 8,
  localparam int CH_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_mode,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_reg,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_space,
  input  logic              bus_write,
  input  logic [1:0]        bus_lanes,
  input  logic [2:0]        bus_ipl,
  input  logic              bus_as,
  input  logic              bus_ds,
  input  logic              int_claim,
  output logic [NUM_CS-1:0] cs_n,
  output logic [NUM_CS-1:0] alt_a,
  output logic [NUM_CS-1:0] alt_b,
  output logic              size_ack,
  output logic              vec_ack
);

  logic                   boot_exp;
  logic [NUM_CS-1:0]      matched, use_ds, avec;
  logic [NUM_CS-1:0][3:0] wait_n;
  logic [NUM_CS-1:0][1:0] pin_fn;

  assign boot_exp = (boot_mode == 2'b01) || (boot_mode == 2'b10);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_ch
    logic sel_here;
    assign sel_here = cfg_we && (cfg_ch == CH_W'(i));

    csd_channel #(
      .ADDR_W(ADDR_W),
      .DW    (DW),
      .BOOT  (i == 0)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .boot_exp (boot_exp),
      .wr_base  (sel_here && (creg_e'(cfg_reg) == CREG_BASE)),
      .wr_opt   (sel_here && (creg_e'(cfg_reg) == CREG_OPT)),
      .wr_pin   (sel_here && (creg_e'(cfg_reg) == CREG_PIN)),
      .wdata    (cfg_wdata),
      .bus_addr (bus_addr),
      .bus_space(bus_space),
      .bus_write(bus_write),
      .bus_lanes(bus_lanes),
      .bus_ipl  (bus_ipl),
      .matched  (matched[i]),
      .use_ds   (use_ds[i]),
      .avec     (avec[i]),
      .wait_n   (wait_n[i]),
      .pin_fn   (pin_fn[i])
    );

    assign cs_n[i]  = ~(matched[i] && (use_ds[i] ? bus_ds : bus_as) && !int_claim);
    assign alt_a[i] = (pin_fn[i] == 2'b00);
    assign alt_b[i] = (pin_fn[i] == 2'b01);
  end

  csd_ack #(.NUM_CS(NUM_CS)) u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_as  (bus_as),
    .is_iack (space_e'(bus_space) == SP_IACK),
    .claim   (int_claim),
    .matched (matched),
    .avec    (avec),
    .wait_n  (wait_n),
    .size_ack(size_ack),
    .vec_ack (vec_ack)
  );

endmodule

// File: rtl/chip_select_decoder_chk.sv
module chip_select_decoder_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_space,
  input logic              bus_as,
  input logic              bus_ds,
  input logic              int_claim,
  input logic [NUM_CS-1:0] cs_n,
  input logic [NUM_CS-1:0] alt_a,
  input logic [NUM_CS-1:0] alt_b,
  input logic              size_ack,
  input logic              vec_ack
);

  assert_claim_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_claim |-> ((&cs_n) && !size_ack && !vec_ack));

  assert_no_strobe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as && !bus_ds) |-> (&cs_n));

  assert_fresh_reset_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (&cs_n[NUM_CS-1:1]));

  assert_size_ack_needs_as_R11: assert property (@(posedge clk) disable iff (!rst_n)
    size_ack |-> bus_as);

  assert_vec_only_iack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |-> (bus_space == 2'd2));

  for (genvar i = 0; i < NUM_CS; i++) begin : g_pin
    assert_alt_pin_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_a[i] || alt_b[i]) |-> cs_n[i]);
  end

endmodule

bind chip_select_decoder chip_select_decoder_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_space(bus_space),
  .bus_as   (bus_as),
  .bus_ds   (bus_ds),
  .int_claim(int_claim),
  .cs_n     (cs_n),
  .alt_a    (alt_a),
  .alt_b    (alt_b),
  .size_ack (size_ack),
  .vec_ack  (vec_ack)
);

// File: tb/chip_select_decoder_test.sv
`timescale 1ns/1ps
module chip_select_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  boot_mode = 2'b10;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [1:0]  cfg_reg = '0;
  logic [15:0] cfg_wdata = '0;
  logic [23:0] bus_addr = '0;
  logic [1:0]  bus_space = '0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_lanes = '0;
  logic [2:0]  bus_ipl = '0;
  logic        bus_as = 1'b0;
  logic        bus_ds = 1'b0;
  logic        int_claim = 1'b0;
  logic [3:0]  cs_n, alt_a, alt_b;
  logic        size_ack, vec_ack;

  int n_checks = 0;
  int n_fail   = 0;

  logic [15:0] m_base [4];
  logic [14:0] m_opt  [4];
  logic [1:0]  m_pin  [4];

  always #10 clk = ~clk;

  chip_select_decoder uut (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
    .bus_addr(bus_addr), .bus_space(bus_space), .bus_write(bus_write),
    .bus_lanes(bus_lanes), .bus_ipl(bus_ipl), .bus_as(bus_as), .bus_ds(bus_ds),
    .int_claim(int_claim), .cs_n(cs_n), .alt_a(alt_a), .alt_b(alt_b),
    .size_ack(size_ack), .vec_ack(vec_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] mkopt(input bit av, input bit ds, input int wt,
                                        input int lvl, input int sp, input int ln, input int rw);
    return {av, ds, 4'(wt), 3'(lvl), 2'(sp), 2'(ln), 2'(rw)};
  endfunction

  function automatic logic [15:0] mkbase(input logic [23:0] a, input int code);
    return {a[23:11], 3'(code)};
  endfunction

  function automatic int size_shift(input logic [2:0] c);
    int t [8] = '{11, 13, 14, 16, 17, 18, 19, 20};
    return t[c];
  endfunction

  // expected active-low select vector, built from the requirements
  function automatic logic [3:0] exp_cs(input logic [23:0] a, input int sp, input bit wr,
                                        input logic [1:0] ln, input int lvl,
                                        input bit as, input bit ds, input bit claim);
    logic [3:0] r = 4'hF;
    for (int c = 0; c < 4; c++) begin
      logic [14:0] o = m_opt[c];
      int sh = size_shift(m_base[c][2:0]);
      bit hit = 1'b1;
      if (o[1:0] == 0 || o[3:2] == 0 || !m_pin[c][1]) hit = 0;
      if ((a >> sh) != ({m_base[c][15:3], 11'b0} >> sh)) hit = 0;
      if (!(wr ? o[1] : o[0])) hit = 0;
      if ((ln & o[3:2]) == 0) hit = 0;
      case (sp)
        0: if (!o[4]) hit = 0;
        1: if (!o[5]) hit = 0;
        2: if (o[5:4] != 0 || (o[8:6] != 0 && o[8:6] != lvl)) hit = 0;
        default: hit = 0;
      endcase
      if (!(o[13] ? ds : as) || claim) hit = 0;
      if (hit) r[c] = 1'b0;
    end
    return r;
  endfunction

  task automatic do_reset(input logic [1:0] mode);
    @(negedge clk);
    rst_n = 1'b0; boot_mode = mode; bus_as = 0; bus_ds = 0; int_claim = 0;
    repeat (2) @(posedge clk);
    for (int c = 0; c < 4; c++) begin
      m_base[c] = '0; m_opt[c] = '0; m_pin[c] = 2'b10;
    end
    if (mode == 2'b01 || mode == 2'b10) begin
      m_base[0] = mkbase(24'h0, 7); m_opt[0] = mkopt(0, 0, 3, 0, 3, 3, 3); m_pin[0] = 2'b11;
    end else m_pin[0] = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wcfg(input int ch, input int rg, input logic [15:0] d);
    @(negedge clk);
    bus_as = 0; bus_ds = 0;
    cfg_we = 1; cfg_ch = 2'(ch); cfg_reg = 2'(rg); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (rg == 0) m_base[ch] = d;
    else if (rg == 1) m_opt[ch] = d[14:0];
    else if (rg == 2) m_pin[ch] = d[1:0];
  endtask

  task automatic apply(input logic [23:0] a, input int sp, input bit wr, input logic [1:0] ln,
                       input int lvl, input bit as, input bit ds, input bit claim, input string tag);
    logic [3:0] e;
    @(negedge clk);
    bus_addr = a; bus_space = 2'(sp); bus_write = wr; bus_lanes = ln;
    bus_ipl = 3'(lvl); bus_as = as; bus_ds = ds; int_claim = claim;
    #5;
    e = exp_cs(a, sp, wr, ln, lvl, as, ds, claim);
    chk(cs_n == e, tag, 32'(cs_n), 32'(e));
  endtask

  // holds one cycle with AS high and checks the acknowledge after each edge
  task automatic ack_run(input logic [23:0] a, input int sp, input bit wr, input logic [1:0] ln,
                         input int lvl, input bit claim, input int wt, input bit isvec,
                         input string tag);
    @(negedge clk);
    bus_as = 0; bus_ds = 0; int_claim = 0;
    @(negedge clk);
    bus_addr = a; bus_space = 2'(sp); bus_write = wr; bus_lanes = ln;
    bus_ipl = 3'(lvl); bus_as = 1; bus_ds = 1; int_claim = claim;
    for (int c = 0; c < 7; c++) begin
      bit e;
      #5;
      e = (wt != 15) && !claim && (c >= wt);
      chk(size_ack == (e && !isvec), tag, 32'(size_ack), 32'(e && !isvec));
      chk(vec_ack == (e && isvec), tag, 32'(vec_ack), 32'(e && isvec));
      @(posedge clk);
      @(negedge clk);
    end
    bus_as = 0; bus_ds = 0; int_claim = 0;
  endtask

  logic [23:0] addrs [10] = '{24'h03FFFF, 24'h040000, 24'h0407FF, 24'h040800, 24'h04FFFF,
                              24'h050000, 24'h0FFFFF, 24'h100000, 24'hFFF7FF, 24'hFFF800};

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R8 R7: 16-bit expanded boot
    do_reset(2'b10);
    apply(24'h000100, 0, 0, 2'b11, 0, 1, 0, 0, "R8 boot channel live");
    chk(alt_a == 4'b0000 && alt_b == 4'b0000, "R8 boot pin function", 32'({alt_a, alt_b}), 0);
    apply(24'h040000, 1, 1, 2'b01, 0, 1, 1, 0, "R7 non-boot channels off");
    // R8: single-chip strap leaves the boot channel off
    do_reset(2'b00);
    apply(24'h000100, 0, 0, 2'b11, 0, 1, 1, 0, "R8 single-chip boot off");
    chk(alt_a == 4'b0001, "R8 R9 boot pin alt A", 32'(alt_a), 32'h1);
    do_reset(2'b01);
    apply(24'h0FFFFF, 1, 1, 2'b10, 0, 1, 0, 0, "R8 8-bit boot live");

    // R1-R5 R10 R6: programmed channels
    wcfg(1, 0, mkbase(24'h040000, 3));
    wcfg(1, 1, mkopt(0, 0, 2, 0, 1, 1, 1));
    wcfg(2, 0, mkbase(24'h040000, 0));
    wcfg(2, 1, mkopt(0, 1, 15, 0, 2, 2, 3));
    wcfg(3, 0, mkbase(24'hFFF800, 0));
    wcfg(3, 1, mkopt(1, 0, 1, 5, 0, 3, 3));
    wcfg(3, 2, 16'h0002);
    for (int ai = 0; ai < 10; ai++)
      for (int sp = 0; sp < 4; sp++)
        for (int wr = 0; wr < 2; wr++)
          for (int ln = 0; ln < 4; ln++)
            for (int lvl = 0; lvl < 8; lvl++)
              for (int st = 0; st < 4; st++)
                for (int cl = 0; cl < 2; cl++)
                  apply(addrs[ai], sp, wr[0], 2'(ln), lvl, st[1], st[0], cl[0],
                        "R1 R2 R3 R4 R5 R6 R10 sweep");

    // R5: overlap of boot and channel 1 asserts both
    apply(24'h040010, 0, 0, 2'b01, 0, 1, 0, 0, "R5 overlap");
    chk(cs_n == 4'b1100, "R5 both selects low", 32'(cs_n), 32'hC);

    // R7: a zero lane or direction field silences the channel
    wcfg(1, 1, mkopt(0, 0, 2, 0, 1, 0, 1));
    apply(24'h040010, 0, 0, 2'b01, 0, 1, 0, 0, "R7 lanes zero");
    chk(cs_n[1] == 1'b1, "R7 lanes zero ch1", 32'(cs_n[1]), 1);
    wcfg(1, 1, mkopt(0, 0, 2, 0, 1, 1, 0));
    apply(24'h040010, 0, 0, 2'b01, 0, 1, 0, 0, "R7 direction zero");
    chk(cs_n[1] == 1'b1, "R7 direction zero ch1", 32'(cs_n[1]), 1);
    wcfg(1, 1, mkopt(0, 0, 2, 0, 1, 1, 1));

    // R9: pin functions
    wcfg(1, 2, 16'h0000);
    apply(24'h040010, 0, 0, 2'b01, 0, 1, 0, 0, "R9 alt A pin");
    chk(alt_a[1] && !alt_b[1] && cs_n[1], "R9 alt A", 32'({alt_a[1], alt_b[1], cs_n[1]}), 32'h5);
    wcfg(1, 2, 16'h0001);
    apply(24'h040010, 0, 0, 2'b01, 0, 1, 0, 0, "R9 alt B pin");
    chk(!alt_a[1] && alt_b[1] && cs_n[1], "R9 alt B", 32'({alt_a[1], alt_b[1], cs_n[1]}), 32'h3);
    wcfg(1, 2, 16'h0002);
    apply(24'h040010, 0, 0, 2'b01, 0, 1, 0, 0, "R9 back to select");

    // R11 R12: internal acknowledges, boot channel switched off first
    wcfg(0, 1, 16'h0000);
    ack_run(24'h040010, 0, 0, 2'b01, 0, 0, 2, 0, "R11 wait 2");
    ack_run(24'h040010, 0, 0, 2'b01, 0, 1, 2, 0, "R6 R11 claimed");
    wcfg(1, 1, mkopt(0, 0, 0, 0, 1, 1, 1));
    ack_run(24'h040010, 0, 0, 2'b01, 0, 0, 0, 0, "R11 wait 0");
    wcfg(1, 1, mkopt(0, 0, 15, 0, 1, 1, 1));
    ack_run(24'h040010, 0, 0, 2'b01, 0, 0, 15, 0, "R11 no ack code");
    ack_run(24'hFFF800, 2, 0, 2'b11, 5, 0, 1, 1, "R12 autovector");
    ack_run(24'hFFF800, 2, 0, 2'b11, 4, 0, 15, 1, "R4 R12 wrong level");
    wcfg(3, 1, mkopt(0, 0, 4, 5, 0, 3, 3));
    ack_run(24'hFFF800, 2, 0, 2'b11, 5, 0, 4, 0, "R12 avec off gives size ack");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule